// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block turns single-beat requests from an internal port into correctly timed strobe sequences for an external 256K x 8 asynchronous static RAM. A requester raises a request strobe with a read/write flag, an 18-bit address and an 8-bit write byte while the controller reports itself ready. The controller then drives the RAM's two chip selects, output enable, write enable, address and data bus. It returns a one-cycle done pulse, and on reads also the byte it fetched.

The RAM has no clock, so every minimum width, access time and bus-release time is a count of controller clock cycles. These counts are fixed at elaboration as the ceiling of each nanosecond limit divided by the clock period, using the limits of the speed grade selected by parameter (70, 85 or 100 ns parts). Reads sample the bus once the access time has elapsed. A write is framed by the overlap of both selects with a low write enable. The data bus is driven only after the RAM has had time to float it, and is released on the edge that ends the write.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and while idle, the active-low select is 1, the active-high select is 0, output enable and write enable are both 1 (inactive), the bus enable is 0, done is 0 and ready is 1.
- R2: A read holds both selects active, output enable low and write enable high for the whole access. Done is high for exactly one cycle and rspRdata then equals the byte stored at the address.
- R3: The read byte is sampled RD = ceil(max(cycle, address access, OE access)/T) clock edges after the selects and address are applied, so done is first seen RD+1 cycles after the accept edge (RD = 7 at 10 ns with the 70 ns grade).
- R4: A write applies selects and address one cycle before write enable falls. Write enable then stays low for WE = max(ceil(pulse), ceil(release)+ceil(data setup), ceil(select-to-end)-1, ceil(write cycle)-2) cycles (WE = 6 at 10 ns, 70 ns grade).
- R5: The controller drives the data bus only while write enable is low, starting no sooner than ceil(release-after-WE-low) cycles after it fell. The byte is held stable for at least the data-setup time before the write ends, and driving stops on the same edge at which write enable rises.
- R6: Selects and address remain applied for one recovery cycle after write enable rises. Done appears WE+3 cycles after the accept edge, and ready is already 1 when done is seen.
- R7: Output enable is never low while write enable is low.
- R8: After a read, ready stays 0 for ceil(output release/T) cycles, counted from the cycle in which done is seen (3 cycles at 10 ns, 70 ns grade).
- R9: Request inputs presented while ready is 0 are ignored: the RAM address stays fixed for the whole access, no extra access or done occurs, and no byte is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, taken when reqReady is 1 |
| reqReady | output | 1 | Controller idle and able to accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Byte address |
| reqWdata | input | 8 | Byte to write |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | 8 | Byte returned by the last read |
| ramCs1N | output | 1 | RAM select, active low |
| ramCs2 | output | 1 | RAM select, active high |
| ramOeN | output | 1 | RAM output enable, active low |
| ramWeN | output | 1 | RAM write enable, active low |
| ramAddr | output | 18 | RAM address |
| ramDqOut | output | 8 | Data driven toward the RAM |
| ramDqOe | output | 1 | Tri-state enable for ramDqOut |
| ramDqIn | input | 8 | Data received from the RAM bus |

## Verification
The hardest case to reach from the ports is a request strobe that stays high while an access is already in flight. A careless controller would re-latch the address mid-access or start a second cycle. The stimulus therefore keeps the strobe raised with a different address, flipped direction and inverted data for several cycles after acceptance, then drops it before ready returns. Later reads of that decoy address confirm nothing was written. A bench RAM model also measures each strobe's age at the falling clock edge, so it flags early bus drive, short write pulses and early sampling. Early sampling shows up as a wrong byte, because the model presents a corrupted value until the access time has elapsed.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  localparam int LIM_RC  = 0;
  localparam int LIM_AA  = 1;
  localparam int LIM_OE  = 2;
  localparam int LIM_HZ  = 3;
  localparam int LIM_WC  = 4;
  localparam int LIM_CW  = 5;
  localparam int LIM_WP  = 6;
  localparam int LIM_DW  = 7;
  localparam int LIM_WHZ = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WADDR,
    ST_WPULSE,
    ST_WREC
  } ctrlState_e;

  typedef struct packed {
    logic selOn;
    logic oeOn;
    logic weOn;
    logic dqOn;
    logic load;
    logic capture;
    logic done;
  } ctrlStrobe_t;

  function automatic int pick3(input int grade, input int g0, input int g1, input int g2);
    return (grade == 0) ? g0 : ((grade == 1) ? g1 : g2);
  endfunction

  // nanosecond limit for grade 0 = 70 ns, 1 = 85 ns, 2 = 100 ns parts
  function automatic int limitNs(input int grade, input int which);
    case (which)
      LIM_RC:  return pick3(grade, 70, 85, 100);
      LIM_AA:  return pick3(grade, 70, 85, 100);
      LIM_OE:  return pick3(grade, 35, 40, 50);
      LIM_HZ:  return pick3(grade, 25, 25, 30);
      LIM_WC:  return pick3(grade, 70, 85, 100);
      LIM_CW:  return pick3(grade, 60, 70, 80);
      LIM_WP:  return pick3(grade, 55, 60, 70);
      LIM_DW:  return pick3(grade, 30, 35, 40);
      LIM_WHZ: return pick3(grade, 25, 30, 30);
      default: return 0;
    endcase
  endfunction

  function automatic int cyclesFor(input int ns, input int periodNs);
    return (ns + periodNs - 1) / periodNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC  = 7,
  parameter int HZ_CYC  = 3,
  parameter int WE_CYC  = 6,
  parameter int WHZ_CYC = 3,
  parameter int CNT_W   = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output ctrlStrobe_t strobe
);

  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_LAST   = CNT_W'(HZ_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LAST   = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] DRV_FIRST = CNT_W'(WHZ_CYC);

  ctrlState_e state, nxtState;
  logic [CNT_W-1:0] cnt, nxtCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxtState;
      cnt   <= nxtCnt;
    end
  end

  always_comb begin
    nxtState = state;
    nxtCnt   = cnt;
    strobe   = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          nxtCnt      = '0;
          nxtState    = reqWrite ? ST_WADDR : ST_READ;
        end
      end
      ST_READ: begin
        if (cnt == RD_LAST) begin
          strobe.capture = 1'b1;
          strobe.done    = 1'b1;
          nxtCnt         = '0;
          nxtState       = ST_TURN;
        end else begin
          nxtCnt = cnt + 1'b1;
        end
      end
      ST_TURN: begin
        if (cnt == HZ_LAST) nxtState = ST_IDLE;
        else nxtCnt = cnt + 1'b1;
      end
      ST_WADDR: begin
        nxtCnt   = '0;
        nxtState = ST_WPULSE;
      end
      ST_WPULSE: begin
        if (cnt == WE_LAST) begin
          nxtCnt   = '0;
          nxtState = ST_WREC;
        end else begin
          nxtCnt = cnt + 1'b1;
        end
      end
      ST_WREC: begin
        strobe.done = 1'b1;
        nxtState    = ST_IDLE;
      end
      default: nxtState = ST_IDLE;
    endcase
    strobe.selOn = (nxtState == ST_READ) || (nxtState == ST_WADDR) ||
                   (nxtState == ST_WPULSE) || (nxtState == ST_WREC);
    strobe.oeOn  = (nxtState == ST_READ);
    strobe.weOn  = (nxtState == ST_WPULSE);
    strobe.dqOn  = (nxtState == ST_WPULSE) && (nxtCnt >= DRV_FIRST);
  end

  assign reqReady = (state == ST_IDLE);

  AST_READ_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TURN) |=> (state == ST_TURN || state == ST_IDLE)); // R8

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] ramDqIn,
  output logic              ramCs1N,
  output logic              ramCs2,
  output logic              ramOeN,
  output logic              ramWeN,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramDqOut,
  output logic              ramDqOe,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspDone
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramCs1N <= 1'b1;
      ramCs2  <= 1'b0;
      ramOeN  <= 1'b1;
      ramWeN  <= 1'b1;
      ramDqOe <= 1'b0;
      rspDone <= 1'b0;
    end else begin
      ramCs1N <= ~strobe.selOn;
      ramCs2  <= strobe.selOn;
      ramOeN  <= ~strobe.oeOn;
      ramWeN  <= ~strobe.weOn;
      ramDqOe <= strobe.dqOn;
      rspDone <= strobe.done;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramAddr  <= '0;
      ramDqOut <= '0;
      rspRdata <= '0;
    end else begin
      if (strobe.load) begin
        ramAddr  <= reqAddr;
        ramDqOut <= reqWdata;
      end
      if (strobe.capture) rspRdata <= ramDqIn;
    end
  end

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!ramOeN && !ramWeN)); // R7
  AST_DQ_ONLY_IN_WE: assert property (@(posedge clk) disable iff (!rstN)
    ramDqOe |-> (!ramWeN && !ramCs1N && ramCs2)); // R5
  AST_DQ_OFF_AT_WE_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramWeN) |-> !ramDqOe); // R5
  AST_WE_AFTER_SEL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ramWeN) |-> $past(!ramCs1N && ramCs2)); // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!ramCs1N && $past(!ramCs1N)) |-> $stable(ramAddr)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone); // R2

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int SPEED_GRADE   = 0,
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic              ramCs1N,
  output logic              ramCs2,
  output logic              ramOeN,
  output logic              ramWeN,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramDqOut,
  output logic              ramDqOe,
  input  logic [DATA_W-1:0] ramDqIn
);

  localparam int T = CLK_PERIOD_NS;
  localparam int G = SPEED_GRADE;

  localparam int RD_CYC = maxOf(maxOf(cyclesFor(limitNs(G, LIM_RC), T),
                                      cyclesFor(limitNs(G, LIM_AA), T)),
                                maxOf(cyclesFor(limitNs(G, LIM_OE), T), 1));
  localparam int HZ_CYC  = maxOf(cyclesFor(limitNs(G, LIM_HZ), T), 1);
  localparam int WHZ_CYC = cyclesFor(limitNs(G, LIM_WHZ), T);
  localparam int DW_CYC  = maxOf(cyclesFor(limitNs(G, LIM_DW), T), 1);
  localparam int WE_CYC  = maxOf(maxOf(cyclesFor(limitNs(G, LIM_WP), T), WHZ_CYC + DW_CYC),
                                 maxOf(cyclesFor(limitNs(G, LIM_CW), T) - 1,
                                       cyclesFor(limitNs(G, LIM_WC), T) - 2));
  localparam int CNT_W   = $clog2(maxOf(maxOf(RD_CYC, HZ_CYC), WE_CYC) + 1);

  ctrlStrobe_t strobe;

  sram_ctrl_fsm #(
    .RD_CYC (RD_CYC),
    .HZ_CYC (HZ_CYC),
    .WE_CYC (WE_CYC),
    .WHZ_CYC(WHZ_CYC),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strobe  (strobe)
  );

  sram_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .ramDqIn (ramDqIn),
    .ramCs1N (ramCs1N),
    .ramCs2  (ramCs2),
    .ramOeN  (ramOeN),
    .ramWeN  (ramWeN),
    .ramAddr (ramAddr),
    .ramDqOut(ramDqOut),
    .ramDqOe (ramDqOe),
    .rspRdata(rspRdata),
    .rspDone (rspDone)
  );

  // window checker: width of each write-enable pulse
  logic [CNT_W-1:0] weLowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) weLowCnt <= '0;
    else if (ramWeN) weLowCnt <= '0;
    else weLowCnt <= weLowCnt + 1'b1;
  end

  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramWeN) |-> (int'(weLowCnt) >= WE_CYC)); // R4
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !rspDone) |-> (ramCs1N && !ramCs2 && ramOeN && ramWeN && !ramDqOe)); // R1
  AST_DONE_READY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (rspDone && $past(!ramWeN, 2)) |-> reqReady); // R6

endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;

  localparam int T      = 10;
  localparam int AA_NS  = 70;
  localparam int HZ_NS  = 25;
  localparam int WP_NS  = 55;
  localparam int WHZ_NS = 25;
  localparam int DW_NS  = 30;
  localparam int CW_NS  = 60;
  localparam int WC_NS  = 70;

  function automatic int bCeil(input int ns);
    return (ns + T - 1) / T;
  endfunction
  function automatic int bMax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int EXP_RD = bCeil(AA_NS);
  localparam int EXP_HZ = bCeil(HZ_NS);
  localparam int EXP_WE = bMax(bMax(bCeil(WP_NS), bCeil(WHZ_NS) + bCeil(DW_NS)),
                               bMax(bCeil(CW_NS) - 1, bCeil(WC_NS) - 2));

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rspDone;
  logic [7:0]  rspRdata;
  logic        ramCs1N, ramCs2, ramOeN, ramWeN, ramDqOe;
  logic [17:0] ramAddr;
  logic [7:0]  ramDqOut;
  logic [7:0]  ramDqIn = '0;

  always #(T/2) clk = ~clk;

  sram_async_ctrl u0 (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspDone(rspDone), .rspRdata(rspRdata),
    .ramCs1N(ramCs1N), .ramCs2(ramCs2), .ramOeN(ramOeN), .ramWeN(ramWeN),
    .ramAddr(ramAddr), .ramDqOut(ramDqOut), .ramDqOe(ramDqOe), .ramDqIn(ramDqIn)
  );

  int nChecks = 0;
  int nFail   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic [7:0] dflt(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // ---------------- RAM model, evaluated at falling edges ----------------
  logic [7:0] ramArr [int];
  int rdAge = 0, selAge = 0, weAge = 0, dAge = 0;
  logic [17:0] rdAddr = '0, wAddr = '0;
  logic [7:0] dVal = '0;

  function automatic logic [7:0] memRead(input logic [17:0] a);
    if (ramArr.exists(int'(a))) return ramArr[int'(a)];
    return dflt(a);
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      automatic bit sel = !ramCs1N && ramCs2;
      automatic bit ov  = sel && !ramWeN;
      selAge = sel ? selAge + 1 : 0;
      if (sel && !ramOeN && ramWeN) begin
        if (rdAge > 0 && ramAddr == rdAddr) rdAge++;
        else begin rdAge = 1; rdAddr = ramAddr; end
      end else rdAge = 0;
      ramDqIn <= (rdAge > 0 && rdAge * T >= AA_NS) ? memRead(ramAddr) : ~memRead(ramAddr);
      if (ov) begin
        weAge++;
        if (weAge == 1) chk(selAge >= 2, "R4 select lead cycles", selAge, 2);
        chk(ramOeN, "R7 OE high in write", int'(ramOeN), 1);
        wAddr = ramAddr;
        if (ramDqOe) begin
          if (dAge > 0 && ramDqOut == dVal) dAge++;
          else begin
            dAge = 1; dVal = ramDqOut;
            chk((weAge - 1) * T >= WHZ_NS, "R5 drive after release ns", (weAge - 1) * T, WHZ_NS);
          end
        end else dAge = 0;
      end else begin
        if (weAge > 0) begin
          chk(weAge == EXP_WE, "R4 WE low cycles", weAge, EXP_WE);
          chk(dAge * T >= DW_NS, "R5 data setup ns", dAge * T, DW_NS);
          chk(sel && ramAddr == wAddr, "R6 recovery hold", int'(sel), 1);
          ramArr[int'(wAddr)] = dVal;
        end
        weAge = 0;
        dAge  = 0;
      end
    end
  end

  // ---------------- reference memory ----------------
  logic [7:0] expArr [int];
  function automatic logic [7:0] expRead(input logic [17:0] a);
    if (expArr.exists(int'(a))) return expArr[int'(a)];
    return dflt(a);
  endfunction

  task automatic doReq(input bit wr, input logic [17:0] a, input logic [7:0] d,
                       input bit junk, output logic [7:0] rd, output int lat);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    lat = 1;
    if (junk) begin
      reqWrite = ~wr; reqAddr = a ^ 18'h2AAAA; reqWdata = ~d;
    end else reqValid = 1'b0;
    while (!rspDone && lat < 1000) begin
      if (lat == 3) reqValid = 1'b0;
      @(negedge clk);
      lat++;
    end
    rd = rspRdata;
  endtask

  task automatic writeOp(input logic [17:0] a, input logic [7:0] d, input bit junk);
    logic [7:0] rd;
    int lat;
    doReq(1'b1, a, d, junk, rd, lat);
    expArr[int'(a)] = d;
    chk(lat == EXP_WE + 3, "R6 write latency", lat, EXP_WE + 3);
    chk(reqReady, "R6 ready at write done", int'(reqReady), 1);
  endtask

  task automatic readOp(input logic [17:0] a, input bit junk);
    logic [7:0] rd;
    int lat;
    int turn;
    doReq(1'b0, a, 8'h00, junk, rd, lat);
    chk(lat == EXP_RD + 1, "R3 read latency", lat, EXP_RD + 1);
    chk(rd == expRead(a), "R2 read data", int'(rd), int'(expRead(a)));
    turn = 0;
    while (!reqReady && turn < 100) begin
      turn++;
      @(negedge clk);
      if (turn == 1) chk(!rspDone, "R2 done single cycle", int'(rspDone), 0);
    end
    chk(turn == EXP_HZ, "R8 turnaround cycles", turn, EXP_HZ);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected completion", cyc);
      finishRun();
    end
  end

  logic [17:0] pool [12];

  initial begin
    void'($urandom(32'h1D5E_0A7));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ramCs1N && !ramCs2, "R1 selects idle in reset", int'({ramCs1N, ramCs2}), 2);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(ramCs1N && !ramCs2, "R1 selects idle", int'({ramCs1N, ramCs2}), 2);
    chk(ramOeN && ramWeN, "R1 OE/WE idle", int'({ramOeN, ramWeN}), 3);
    chk(!ramDqOe && !rspDone, "R1 bus and done idle", int'({ramDqOe, rspDone}), 0);
    chk(reqReady, "R1 ready", int'(reqReady), 1);

    // directed corners
    readOp(18'h00000, 1'b0);
    writeOp(18'h00000, 8'h5A, 1'b0);
    readOp(18'h00000, 1'b0);
    writeOp(18'h3FFFF, 8'hA5, 1'b0);
    readOp(18'h3FFFF, 1'b0);
    writeOp(18'h15555, 8'hFF, 1'b0);
    writeOp(18'h15555, 8'h00, 1'b0);
    readOp(18'h15555, 1'b0);

    // R9: strobe held during a busy access with a decoy write
    writeOp(18'h01234, 8'h77, 1'b0);
    readOp(18'h01234 ^ 18'h2AAAA, 1'b1);
    readOp(18'h01234, 1'b0);
    chk(!rspDone && ramCs1N, "R9 no extra access after decoy", int'({rspDone, ramCs1N}), 1);
    writeOp(18'h00ABC, 8'h3E, 1'b1);
    readOp(18'h00ABC ^ 18'h2AAAA, 1'b0);
    readOp(18'h00ABC, 1'b0);

    // random traffic
    foreach (pool[i]) pool[i] = 18'($urandom);
    for (int k = 0; k < 80; k++) begin
      automatic logic [17:0] a = pool[$urandom % 12];
      automatic bit junk = ($urandom % 5) == 0;
      if ($urandom % 2) writeOp(a, 8'($urandom), junk);
      else readOp(a, junk);
    end
    foreach (pool[i]) readOp(pool[i], 1'b0);

    repeat (4) @(negedge clk);
    chk(!rspDone && reqReady, "R9 quiet after traffic", int'({rspDone, reqReady}), 1);
    finishRun();
  end

endmodule